// File: doc/BRIEF.md
# Prioritized Interrupt Request Controller

The controller gathers 27 normal interrupt requests, 23 from internal peripherals and 4 from external pins, and reduces them to one prioritized request line plus a source number for the processor. Every source is given a 3-bit priority and may be set to level-sensitive or rising-edge-sensitive capture. A separate fast-interrupt input bypasses arbitration entirely and is passed to its own output.

Software drives the block through a small word-addressed register bus with address, write data, read data, and write and read strobes. The handler reads the source-number register. That read acknowledges the interrupt and raises the current service level to the winner's priority. Writing the service-level register ends the service and drops the level back to zero. Edge-captured requests are cleared by writing ones to the pending register.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, `irq_o` and `fiq_o` are 0, every priority, edge, mask and service-level register reads 0, and the source-number register (address 11) reads 31.
- R2: A source whose priority is 0 never raises `irq_o` and never wins arbitration, even while its request is active.
- R3: Among eligible sources, which are pending, unmasked and have a nonzero priority, the one with the highest priority wins. Priority 7 is the highest. Source k's 3-bit priority sits at address k/8, bits [4*(k%8)+2 : 4*(k%8)].
- R4: When several eligible sources share the highest priority, the lowest-numbered one wins.
- R5: Setting bit k of the mask register (address 9) removes source k from arbitration. Its pending bit (address 10, bit k) still shows the request.
- R6: With bit k of the edge register (address 8) set, a rising edge on source k sets pending bit k. The bit stays set after the request falls, until a write to address 10 with bit k = 1 clears it.
- R7: With bit k of the edge register clear, pending bit k follows the request one cycle later.
- R8: A read strobe on address 11 while a winner exists loads the service level (address 12) with the winner's priority. From then on, `irq_o` is asserted only for a winner of strictly higher priority.
- R9: Any write to address 12 resets the service level to 0, so that a waiting winner asserts `irq_o` again.
- R10: `fiq_o` equals `fiq_req_i` delayed by one clock, independent of masks, priorities and service level.
- R11: `irq_id_o` and the source-number register give the winning source index. Both give 31 when no source is eligible. Internal requests are sources 0–22 and external requests are sources 23–26.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| int_req_i | input | 23 | Internal peripheral requests, sources 0–22 |
| ext_req_i | input | 4 | External pin requests, sources 23–26 |
| fiq_req_i | input | 1 | Dedicated fast-interrupt request |
| addr_i | input | 4 | Register word address |
| wdata_i | input | 32 | Register write data |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe (acknowledge on address 11) |
| rdata_o | output | 32 | Register read data, combinational from `addr_i` |
| irq_o | output | 1 | Prioritized interrupt request |
| irq_id_o | output | 5 | Winning source index, 31 when none |
| fiq_o | output | 1 | Fast-interrupt output |

## Verification
The bench targets priority ties, disabled and masked sources, and the idle code 31. An arbiter scanning in the wrong direction would report the higher-numbered source in a tie. A design that ignores priority 0 would fire on a disabled source. Nested service is driven with an equal-priority request and then a strictly higher one. A `>=` comparison against the service level would re-raise the request on the equal one. An edge request is pulsed for a single cycle and cleared by write-one. Logic that loses the latch would drop the request early, and a broken clear would leave it stuck.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int LVL_W = 3;
  localparam int ID_W  = 5;
  localparam int AW    = 4;
  localparam int DW    = 32;
  localparam int FLD_W = 4;  // priority field pitch in a word
  localparam logic [ID_W-1:0] NO_SRC = '1;

  typedef enum logic [AW-1:0] {
    A_EDGE = 4'd8,
    A_MASK = 4'd9,
    A_PEND = 4'd10,
    A_SRC  = 4'd11,
    A_CUR  = 4'd12
  } ctrl_addr_e;
endpackage

// File: rtl/irqc_pend.sv
module irqc_pend #(
  parameter int N = 27
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] req_i,
  input  logic [N-1:0] edge_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] pend_o
);
  logic [N-1:0] req_q, pend_q;

  for (genvar k = 0; k < N; k++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        req_q[k]  <= 1'b0;
        pend_q[k] <= 1'b0;
      end else begin
        req_q[k] <= req_i[k];
        if (edge_i[k]) pend_q[k] <= (req_i[k] & ~req_q[k]) | (pend_q[k] & ~clr_i[k]);
        else           pend_q[k] <= req_i[k];
      end
    end
  end

  assign pend_o = pend_q;

  // latched edge bits only drop on an explicit clear
  assert_edge_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1 |=> (!$stable(edge_i) || (($past(pend_q & edge_i & ~clr_i) & ~pend_q) == '0)));
endmodule

// File: rtl/irqc_arb.sv
module irqc_arb #(
  parameter int N  = 27,
  parameter int LW = 3,
  parameter int IW = 5
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [N-1:0]           elig_i,
  input  logic [N-1:0][LW-1:0]   lvl_i,
  output logic                   valid_o,
  output logic [IW-1:0]          id_o,
  output logic [LW-1:0]          lvl_o
);
  always_comb begin
    lvl_o = '0;
    id_o  = '1;
    // descending scan with >= leaves the lowest index on ties
    for (int i = N - 1; i >= 0; i--) begin
      if (elig_i[i] && lvl_i[i] >= lvl_o) begin
        lvl_o = lvl_i[i];
        id_o  = IW'(i);
      end
    end
  end
  assign valid_o = |elig_i;

  assert_win_elig_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> elig_i[id_o]);
  assert_idle_id_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> (id_o == '1));

  for (genvar k = 0; k < N; k++) begin : g_chk
    assert_max_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      elig_i[k] |-> (lvl_i[k] <= lvl_o));
    assert_tie_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (elig_i[k] && lvl_i[k] == lvl_o) |-> (k >= int'(id_o)));
  end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import irqc_pkg::*;
#(
  parameter int N_INT = 23,
  parameter int N_EXT = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_INT-1:0] int_req_i,
  input  logic [N_EXT-1:0] ext_req_i,
  input  logic             fiq_req_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [DW-1:0]    wdata_i,
  input  logic             wr_i,
  input  logic             rd_i,
  output logic [DW-1:0]    rdata_o,
  output logic             irq_o,
  output logic [ID_W-1:0]  irq_id_o,
  output logic             fiq_o
);
  localparam int N       = N_INT + N_EXT;
  localparam int PER_WD  = DW / FLD_W;

  logic [N-1:0][LVL_W-1:0] prio_q;
  logic [N-1:0]            edge_q, mask_q, pend, elig, clr;
  logic [LVL_W-1:0]        cur_q, win_lvl;
  logic [ID_W-1:0]         win_id, id_q;
  logic                    win_valid, irq_q, fiq_q;
  logic                    ack, fin;

  assign ack = rd_i && addr_i == A_SRC && win_valid;
  assign fin = wr_i && addr_i == A_CUR;
  assign clr = (wr_i && addr_i == A_PEND) ? wdata_i[N-1:0] : '0;

  for (genvar k = 0; k < N; k++) begin : g_prio
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) prio_q[k] <= '0;
      else if (wr_i && addr_i == AW'(k / PER_WD))
        prio_q[k] <= wdata_i[FLD_W*(k % PER_WD) +: LVL_W];
    end
    assign elig[k] = pend[k] && !mask_q[k] && prio_q[k] != '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      edge_q <= '0;
      mask_q <= '0;
      cur_q  <= '0;
      irq_q  <= 1'b0;
      id_q   <= NO_SRC;
      fiq_q  <= 1'b0;
    end else begin
      if (wr_i && addr_i == A_EDGE) edge_q <= wdata_i[N-1:0];
      if (wr_i && addr_i == A_MASK) mask_q <= wdata_i[N-1:0];
      if (ack)      cur_q <= win_lvl;
      else if (fin) cur_q <= '0;
      irq_q <= win_valid && (win_lvl > cur_q);
      id_q  <= win_id;
      fiq_q <= fiq_req_i;
    end
  end

  irqc_pend #(.N(N)) u_pend (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .req_i ({ext_req_i, int_req_i}),
    .edge_i(edge_q),
    .clr_i (clr),
    .pend_o(pend)
  );

  irqc_arb #(.N(N), .LW(LVL_W), .IW(ID_W)) u_arb (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .elig_i (elig),
    .lvl_i  (prio_q),
    .valid_o(win_valid),
    .id_o   (win_id),
    .lvl_o  (win_lvl)
  );

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      A_EDGE: rdata_o[N-1:0] = edge_q;
      A_MASK: rdata_o[N-1:0] = mask_q;
      A_PEND: rdata_o[N-1:0] = pend;
      A_SRC:  rdata_o[ID_W-1:0] = win_id;
      A_CUR:  rdata_o[LVL_W-1:0] = cur_q;
      default:
        for (int k = 0; k < N; k++)
          if (addr_i == AW'(k / PER_WD))
            rdata_o[FLD_W*(k % PER_WD) +: LVL_W] = prio_q[k];
    endcase
  end

  assign irq_o    = irq_q;
  assign irq_id_o = id_q;
  assign fiq_o    = fiq_q;

  assert_fiq_follow_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) |-> (fiq_o == $past(fiq_req_i)));
  assert_ack_level_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack |=> (cur_q == $past(win_lvl)));
  assert_end_clear_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fin && !ack) |=> (cur_q == '0));
  assert_masked_out_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    win_valid |-> !mask_q[win_id]);
  assert_zero_prio_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    win_valid |-> (win_lvl != '0));
endmodule

// File: tb/tb_prio_irq_ctrl.sv
`timescale 1ns/1ps
module tb_prio_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [26:0] src = '0;
  logic        fiq_req = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [31:0] rdata;
  logic        irq, fiq;
  logic [4:0]  irq_id;
  int          n_chk = 0, n_fail = 0;
  logic [31:0] rv;

  always #2 clk = ~clk;

  prio_irq_ctrl dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .int_req_i(src[22:0]), .ext_req_i(src[26:23]), .fiq_req_i(fiq_req),
    .addr_i(addr), .wdata_i(wdata), .wr_i(wr), .rd_i(rd),
    .rdata_o(rdata), .irq_o(irq), .irq_id_o(irq_id), .fiq_o(fiq)
  );

  // {pattern[26:0], irq expected, id}
  localparam logic [32:0] TBL [9] = '{
    {27'(1 << 0),                          1'b1, 5'd0},
    {27'((1 << 0) | (1 << 20)),            1'b1, 5'd20},
    {27'((1 << 3) | (1 << 7)),             1'b1, 5'd3},
    {27'((1 << 7) | (1 << 20)),            1'b1, 5'd7},
    {27'((1 << 10) | (1 << 26) | (1 << 3)),1'b1, 5'd10},
    {27'(1 << 26),                         1'b1, 5'd26},
    {27'(1 << 15),                         1'b0, 5'd31},
    {27'(0),                               1'b0, 5'd31},
    {27'((1 << 15) | (1 << 20)),           1'b1, 5'd20}
  };

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [3:0] a, input bit strobe, output logic [31:0] d);
    @(negedge clk); addr = a; rd = strobe;
    #1 d = rdata;
    @(negedge clk); rd = 1'b0;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #400000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(irq == 1'b0, "R1", 32'(irq), 0);
    check(fiq == 1'b0, "R1", 32'(fiq), 0);
    rst_ni = 1'b1;
    @(negedge clk);
    rd_reg(4'd11, 1'b0, rv); check(rv == 31, "R1", rv, 31);
    for (int a = 0; a < 4; a++) begin
      rd_reg(4'(a), 1'b0, rv); check(rv == 0, "R1", rv, 0);
    end
    rd_reg(4'd12, 1'b0, rv); check(rv == 0, "R1", rv, 0);

    // priorities: s0=1 s3=5 s7=5 s10=7 s15=0 s20=2 s26=7
    wr_reg(4'd0, 32'h5000_5001);
    wr_reg(4'd1, 32'h0000_0700);
    wr_reg(4'd2, 32'h0002_0000);
    wr_reg(4'd3, 32'h0000_0700);
    rd_reg(4'd0, 1'b0, rv); check(rv == 32'h5000_5001, "R3", rv, 32'h5000_5001);

    // level-mode table: R2 R3 R4 R7 R11
    for (int i = 0; i < 9; i++) begin
      src = TBL[i][32:6];
      settle();
      check(irq == TBL[i][5], "R3/R4/R2", 32'(irq), 32'(TBL[i][5]));
      check(irq_id == TBL[i][4:0], "R11", 32'(irq_id), 32'(TBL[i][4:0]));
    end
    src = 27'(1 << 20); settle();
    rd_reg(4'd10, 1'b0, rv); check(rv == 32'(1 << 20), "R7", rv, 32'(1 << 20));
    src = '0; settle();
    rd_reg(4'd10, 1'b0, rv); check(rv == 0, "R7", rv, 0);

    // R5 mask
    wr_reg(4'd9, 32'(1 << 26));
    src = 27'((1 << 26) | (1 << 3)); settle();
    check(irq_id == 5'd3, "R5", 32'(irq_id), 3);
    rd_reg(4'd10, 1'b0, rv); check(rv == 32'((1 << 26) | (1 << 3)), "R5", rv, 32'((1 << 26) | (1 << 3)));
    wr_reg(4'd9, 32'h0);
    src = '0; settle();

    // R6 edge latch and write-one clear
    wr_reg(4'd8, 32'(1 << 20));
    @(negedge clk); src[20] = 1'b1;
    @(negedge clk); src[20] = 1'b0;
    settle();
    check(irq == 1'b1 && irq_id == 5'd20, "R6", {27'b0, irq_id}, 20);
    rd_reg(4'd10, 1'b0, rv); check(rv == 32'(1 << 20), "R6", rv, 32'(1 << 20));
    wr_reg(4'd10, 32'(1 << 20)); settle();
    check(irq == 1'b0, "R6", 32'(irq), 0);
    rd_reg(4'd10, 1'b0, rv); check(rv == 0, "R6", rv, 0);
    wr_reg(4'd8, 32'h0);

    // R8 acknowledge and nesting
    src = 27'(1 << 3); settle();
    check(irq == 1'b1, "R8", 32'(irq), 1);
    rd_reg(4'd11, 1'b1, rv); check(rv == 3, "R8", rv, 3);
    settle();
    check(irq == 1'b0, "R8", 32'(irq), 0);
    rd_reg(4'd12, 1'b0, rv); check(rv == 5, "R8", rv, 5);
    src = 27'((1 << 3) | (1 << 7)); settle();
    check(irq == 1'b0, "R8", 32'(irq), 0);
    src = 27'((1 << 3) | (1 << 10)); settle();
    check(irq == 1'b1 && irq_id == 5'd10, "R8", {27'b0, irq_id}, 10);

    // R9 end of service
    src = 27'(1 << 3); settle();
    check(irq == 1'b0, "R9", 32'(irq), 0);
    wr_reg(4'd12, 32'h0); settle();
    rd_reg(4'd12, 1'b0, rv); check(rv == 0, "R9", rv, 0);
    check(irq == 1'b1 && irq_id == 5'd3, "R9", {27'b0, irq_id}, 3);

    // R10 fast path ignores masks
    wr_reg(4'd9, 32'h07ff_ffff);
    @(negedge clk); fiq_req = 1'b1;
    @(negedge clk); check(fiq == 1'b1, "R10", 32'(fiq), 1);
    fiq_req = 1'b0;
    @(negedge clk); check(fiq == 1'b0, "R10", 32'(fiq), 0);
    settle();
    check(irq == 1'b0 && irq_id == 5'd31, "R11", {27'b0, irq_id}, 31);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule